// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block sits beside the execution pipeline of a 32-bit CPU core and decides when a pending request is taken. There are four request sources: a synchronous exception, a fast hardware request, a normal hardware request and a software request. Once it accepts one, the block runs the whole entry sequence while its busy output stalls the core. The sequence clears the sleep state, saves context, fetches the new program counter and builds the new status word. The core applies the result in a single commit cycle.

There are two ways to save context. A normal entry pushes the packed status word and then the return PC onto the interrupt stack through a write port. It then reads the handler address from a vector table through a read port. A fast entry copies the PC and the status word into backup registers and takes its handler address from a dedicated register, so it makes no memory traffic at all. Exceptions index a fixed table at `0xFFFFFFC0`. Hardware and software interrupts index the relocatable table base.

The core keeps each request line high until the matching clear pulse arrives. When several requests are pending, the one not taken stays pending. It is re-evaluated once the current entry has committed.

Top module: `irq_entry_seq`

## Requirements
- R1: A software request is accepted whatever the interrupt-enable bit and current priority level are.
- R2: A normal hardware request is accepted only when interrupt-enable (status bit 16) is 1 and the current level (status bits 27:24) is strictly below `hw_lvl`. Otherwise no entry starts, and `busy` and `wake` stay low.
- R3: A fast request is accepted only when interrupt-enable is 1 and the current level is below 15.
- R4: Priority is exception, then fast, then normal hardware, then software. Only the taken source's clear pulse fires. A request that is not taken stays pending and is taken by a later entry.
- R5: In the cycle after acceptance, `wake` and exactly one clear output pulse for one cycle.
- R6: When the user-mode bit (status bit 17) is 1, the commit reports `usp_upd` with `usp_val` equal to `cur_r0`, and the stack base is `cur_isp`. When it is 0, the stack base is `cur_r0`.
- R7: A normal entry writes the status word to base-4 and then the PC to base-8. At commit, `new_sp` is base-8.
- R8: A fast entry makes no memory access. At commit it raises `bk_upd` with `bk_pc` = PC and `bk_psw` = status word, and gives `new_sp` = base and `new_pc` = `fast_pc`.
- R9: The committed status word has the processor-mode bit (bit 20), the interrupt-enable bit and the user-mode bit cleared. Its level field is 15 for a fast entry, `hw_lvl` for a normal hardware entry, and unchanged otherwise. All other bits are kept.
- R10: `ack` pulses together with the clear pulse for fast and normal hardware entries only.
- R11: The vector read address is `tbl_base + vector*4` for interrupts and `0xFFFFFFC0 + exc_code*4` (modulo 2^32) for exceptions. `new_pc` is the data returned by that read.
- R12: A memory request keeps its enable, address and data until ready. `busy` is high from the cycle after acceptance through the commit cycle. After reset, `busy`, both memory enables and `commit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_sw | input | 1 | Software request pending |
| req_hw | input | 1 | Normal hardware request pending |
| req_fast | input | 1 | Fast hardware request pending |
| req_exc | input | 1 | Exception pending |
| hw_vec | input | VEC_W | Hardware vector number |
| hw_lvl | input | 4 | Hardware request level |
| sw_vec | input | VEC_W | Software vector number |
| exc_code | input | EXC_W | Exception number |
| cur_psw | input | XLEN | Current packed status word |
| cur_pc | input | XLEN | Return PC |
| cur_r0 | input | XLEN | Live stack pointer |
| cur_isp | input | XLEN | Interrupt stack pointer |
| tbl_base | input | XLEN | Relocatable vector table base |
| fast_pc | input | XLEN | Fast handler address |
| busy | output | 1 | Entry in progress; stalls the core |
| wake | output | 1 | Pulse: leave sleep state |
| clr_sw | output | 1 | Pulse: software request taken |
| clr_hw | output | 1 | Pulse: hardware request taken |
| clr_fast | output | 1 | Pulse: fast request taken |
| clr_exc | output | 1 | Pulse: exception taken |
| ack | output | 1 | Pulse: acknowledge to interrupt controller |
| mem_wr_en | output | 1 | Stack write request |
| mem_wr_addr | output | XLEN | Stack write address |
| mem_wr_data | output | XLEN | Stack write data |
| mem_wr_rdy | input | 1 | Write accepted |
| mem_rd_en | output | 1 | Vector read request |
| mem_rd_addr | output | XLEN | Vector read address |
| mem_rd_data | input | XLEN | Read data, valid with ready |
| mem_rd_rdy | input | 1 | Read data valid |
| commit | output | 1 | Pulse: apply the results below |
| new_pc | output | XLEN | Handler PC |
| new_psw | output | XLEN | New status word |
| new_sp | output | XLEN | New interrupt stack pointer and register 0 |
| usp_upd | output | 1 | With commit: write user stack pointer |
| usp_val | output | XLEN | Value for user stack pointer |
| bk_upd | output | 1 | With commit: write backup registers |
| bk_pc | output | XLEN | Backup PC value |
| bk_psw | output | XLEN | Backup status value |

## Verification
The embedded properties assume that the memory side raises ready only while the matching enable is high. They also assume that a request line stays high until its clear pulse and that the status and level inputs are steady in the accepting cycle, so the properties can relate a clear pulse back to the gating inputs one cycle earlier. The bench follows these rules. Its request registers are set by the driver and drop only on a clear pulse or an explicit withdrawal. Its wait-state responder produces ready solely while an enable is seen. Status, vectors and pointers change only while the block is idle and nothing is pending. The latency varies between cases so that held requests are exercised.

// File: rtl/irq_entry_pkg.sv
// Shared definitions for the interrupt entry sequencer.
// Assumes a 32-bit packed status word with the field positions below.
package irq_entry_pkg;
    localparam int PSW_I_BIT  = 16;
    localparam int PSW_U_BIT  = 17;
    localparam int PSW_PM_BIT = 20;
    localparam int IPL_LSB    = 24;
    localparam int IPL_W      = 4;
    localparam logic [IPL_W-1:0] IPL_TOP = '1;

    typedef enum logic [2:0] {
        EK_NONE, EK_EXC, EK_FAST, EK_HW, EK_SW
    } entry_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SAVE_PSW, ST_SAVE_PC, ST_FETCH_VEC, ST_DONE
    } seq_state_e;
endpackage

// File: rtl/irq_accept.sv
// Acceptance and priority for the four request sources.
// Purely combinational; assumes requests are levels held until cleared.
module irq_accept
    import irq_entry_pkg::*;
(
    input  logic             req_exc,
    input  logic             req_fast,
    input  logic             req_hw,
    input  logic             req_sw,
    input  logic             int_en,
    input  logic [IPL_W-1:0] cur_ipl,
    input  logic [IPL_W-1:0] hw_lvl,
    output logic             take,
    output entry_kind_e      kind
);
    logic fast_ok, hw_ok;

    // Gate each hardware source by enable and level.
    always_comb begin
        fast_ok = req_fast && int_en && (cur_ipl != IPL_TOP);
        hw_ok   = req_hw && int_en && (cur_ipl < hw_lvl);
    end

    // Fixed priority: exception, fast, normal hardware, software.
    always_comb begin
        if (req_exc)      kind = EK_EXC;
        else if (fast_ok) kind = EK_FAST;
        else if (hw_ok)   kind = EK_HW;
        else if (req_sw)  kind = EK_SW;
        else              kind = EK_NONE;
        take = (kind != EK_NONE);
    end
endmodule

// File: rtl/irq_vec_addr.sv
// Computes the vector table address for the accepted source.
// Assumes table entries one machine word wide.
module irq_vec_addr
    import irq_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              VEC_W    = 8,
    parameter int              EXC_W    = 5,
    parameter logic [XLEN-1:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  entry_kind_e      kind,
    input  logic [VEC_W-1:0] hw_vec,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic [EXC_W-1:0] exc_code,
    input  logic [XLEN-1:0]  tbl_base,
    output logic [XLEN-1:0]  vec_addr
);
    localparam int SHIFT = $clog2(XLEN / 8);

    logic [XLEN-1:0] idx, base;

    // Select index and base, then scale index by the word size.
    always_comb begin
        case (kind)
            EK_EXC: begin
                idx  = XLEN'(exc_code);
                base = EXC_BASE;
            end
            EK_SW: begin
                idx  = XLEN'(sw_vec);
                base = tbl_base;
            end
            default: begin
                idx  = XLEN'(hw_vec);
                base = tbl_base;
            end
        endcase
        vec_addr = base + (idx << SHIFT);
    end
endmodule

// File: rtl/irq_psw_next.sv
// Builds the status word used after entry.
// Assumes field positions from the package.
module irq_psw_next
    import irq_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  cur_psw,
    input  entry_kind_e      kind,
    input  logic [IPL_W-1:0] hw_lvl,
    output logic [XLEN-1:0]  next_psw
);
    // Clear mode and enable bits; set level for hardware entries.
    always_comb begin
        next_psw             = cur_psw;
        next_psw[PSW_PM_BIT] = 1'b0;
        next_psw[PSW_I_BIT]  = 1'b0;
        next_psw[PSW_U_BIT]  = 1'b0;
        if (kind == EK_FAST)
            next_psw[IPL_LSB +: IPL_W] = IPL_TOP;
        else if (kind == EK_HW)
            next_psw[IPL_LSB +: IPL_W] = hw_lvl;
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer: accepts one request, saves context to the
// stack or to backup registers, fetches the handler PC and commits.
// Assumes the core holds request lines until the matching clear pulse,
// and that memory ready is raised only while the enable is high.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              VEC_W    = 8,
    parameter int              EXC_W    = 5,
    parameter logic [XLEN-1:0] EXC_BASE = 32'hFFFF_FFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sw,
    input  logic             req_hw,
    input  logic             req_fast,
    input  logic             req_exc,
    input  logic [VEC_W-1:0] hw_vec,
    input  logic [IPL_W-1:0] hw_lvl,
    input  logic [VEC_W-1:0] sw_vec,
    input  logic [EXC_W-1:0] exc_code,
    input  logic [XLEN-1:0]  cur_psw,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_r0,
    input  logic [XLEN-1:0]  cur_isp,
    input  logic [XLEN-1:0]  tbl_base,
    input  logic [XLEN-1:0]  fast_pc,
    output logic             busy,
    output logic             wake,
    output logic             clr_sw,
    output logic             clr_hw,
    output logic             clr_fast,
    output logic             clr_exc,
    output logic             ack,
    output logic             mem_wr_en,
    output logic [XLEN-1:0]  mem_wr_addr,
    output logic [XLEN-1:0]  mem_wr_data,
    input  logic             mem_wr_rdy,
    output logic             mem_rd_en,
    output logic [XLEN-1:0]  mem_rd_addr,
    input  logic [XLEN-1:0]  mem_rd_data,
    input  logic             mem_rd_rdy,
    output logic             commit,
    output logic [XLEN-1:0]  new_pc,
    output logic [XLEN-1:0]  new_psw,
    output logic [XLEN-1:0]  new_sp,
    output logic             usp_upd,
    output logic [XLEN-1:0]  usp_val,
    output logic             bk_upd,
    output logic [XLEN-1:0]  bk_pc,
    output logic [XLEN-1:0]  bk_psw
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(XLEN / 8);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * (XLEN / 8));

    seq_state_e      state;
    entry_kind_e     kind, kind_q;
    logic            take, user_q;
    logic [XLEN-1:0] vec_addr, next_psw, base;
    logic [XLEN-1:0] pc_q, psw_q, base_q, sp_q, npsw_q, vaddr_q, npc_q, r0_q;

    irq_accept u_accept (
        .req_exc  (req_exc),
        .req_fast (req_fast),
        .req_hw   (req_hw),
        .req_sw   (req_sw),
        .int_en   (cur_psw[PSW_I_BIT]),
        .cur_ipl  (cur_psw[IPL_LSB +: IPL_W]),
        .hw_lvl   (hw_lvl),
        .take     (take),
        .kind     (kind)
    );

    irq_vec_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .EXC_W(EXC_W), .EXC_BASE(EXC_BASE)) u_vaddr (
        .kind     (kind),
        .hw_vec   (hw_vec),
        .sw_vec   (sw_vec),
        .exc_code (exc_code),
        .tbl_base (tbl_base),
        .vec_addr (vec_addr)
    );

    irq_psw_next #(.XLEN(XLEN)) u_psw (
        .cur_psw  (cur_psw),
        .kind     (kind),
        .hw_lvl   (hw_lvl),
        .next_psw (next_psw)
    );

    // Stack base: the live pointer already is the interrupt stack in supervisor mode.
    always_comb base = cur_psw[PSW_U_BIT] ? cur_isp : cur_r0;

    // Sequencer: latch context on acceptance, walk the save/fetch steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind_q   <= EK_NONE;
            wake     <= 1'b0;
            clr_sw   <= 1'b0;
            clr_hw   <= 1'b0;
            clr_fast <= 1'b0;
            clr_exc  <= 1'b0;
            ack      <= 1'b0;
            user_q   <= 1'b0;
            pc_q     <= '0;
            psw_q    <= '0;
            base_q   <= '0;
            sp_q     <= '0;
            npsw_q   <= '0;
            vaddr_q  <= '0;
            npc_q    <= '0;
            r0_q     <= '0;
        end else begin
            wake     <= 1'b0;
            clr_sw   <= 1'b0;
            clr_hw   <= 1'b0;
            clr_fast <= 1'b0;
            clr_exc  <= 1'b0;
            ack      <= 1'b0;
            case (state)
                ST_IDLE: if (take) begin
                    kind_q   <= kind;
                    pc_q     <= cur_pc;
                    psw_q    <= cur_psw;
                    base_q   <= base;
                    sp_q     <= (kind == EK_FAST) ? base : base - STEP2;
                    user_q   <= cur_psw[PSW_U_BIT];
                    r0_q     <= cur_r0;
                    npsw_q   <= next_psw;
                    vaddr_q  <= vec_addr;
                    npc_q    <= fast_pc;
                    wake     <= 1'b1;
                    clr_exc  <= (kind == EK_EXC);
                    clr_fast <= (kind == EK_FAST);
                    clr_hw   <= (kind == EK_HW);
                    clr_sw   <= (kind == EK_SW);
                    ack      <= (kind == EK_FAST) || (kind == EK_HW);
                    state    <= (kind == EK_FAST) ? ST_DONE : ST_SAVE_PSW;
                end
                ST_SAVE_PSW:  if (mem_wr_rdy) state <= ST_SAVE_PC;
                ST_SAVE_PC:   if (mem_wr_rdy) state <= ST_FETCH_VEC;
                ST_FETCH_VEC: if (mem_rd_rdy) begin
                    npc_q <= mem_rd_data;
                    state <= ST_DONE;
                end
                default:      state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state and latched context.
    always_comb begin
        busy        = (state != ST_IDLE);
        mem_wr_en   = (state == ST_SAVE_PSW) || (state == ST_SAVE_PC);
        mem_wr_addr = (state == ST_SAVE_PC) ? base_q - STEP2 : base_q - STEP;
        mem_wr_data = (state == ST_SAVE_PC) ? pc_q : psw_q;
        mem_rd_en   = (state == ST_FETCH_VEC);
        mem_rd_addr = vaddr_q;
        commit      = (state == ST_DONE);
        new_pc      = npc_q;
        new_psw     = npsw_q;
        new_sp      = sp_q;
        usp_upd     = commit && user_q;
        usp_val     = r0_q;
        bk_upd      = commit && (kind_q == EK_FAST);
        bk_pc       = pc_q;
        bk_psw      = psw_q;
    end

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en && !mem_wr_rdy |=> mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data));
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !mem_rd_rdy |=> mem_rd_en && $stable(mem_rd_addr));
    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && take |=> busy && wake);
    // R2
    hw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hw |-> $past(cur_psw[PSW_I_BIT] && (cur_psw[IPL_LSB +: IPL_W] < hw_lvl)));
    // R3
    fast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fast |-> $past(cur_psw[PSW_I_BIT] && (cur_psw[IPL_LSB +: IPL_W] != IPL_TOP)));
    // R5
    one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_sw, clr_hw, clr_fast, clr_exc}));
    // R10
    ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> clr_hw || clr_fast);
    // R8
    fast_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (kind_q == EK_FAST) |-> !mem_wr_en && !mem_rd_en);
    // R9
    psw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !new_psw[PSW_PM_BIT] && !new_psw[PSW_I_BIT] && !new_psw[PSW_U_BIT]);
endmodule

// File: tb/sim_irq_entry_seq.sv
// Scoreboard bench: driver tasks queue expected bus and commit items,
// a monitor at the falling edge pops and compares them.
module sim_irq_entry_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_sw = 0, req_hw = 0, req_fast = 0, req_exc = 0;
    logic set_sw = 0, set_hw = 0, set_fast = 0, set_exc = 0, drop_all = 0;
    logic [7:0]  hw_vec = 8'h40, sw_vec = 8'h1B;
    logic [3:0]  hw_lvl = 4'd9;
    logic [4:0]  exc_code = 5'd0;
    logic [31:0] cur_psw = 0, cur_pc = 32'h0000_1234, cur_r0 = 32'h0002_0000;
    logic [31:0] cur_isp = 32'h0003_0000, tbl_base = 32'h0010_0000, fast_pc = 32'h0000_8000;
    logic        mem_wr_rdy = 0, mem_rd_rdy = 0;
    logic [31:0] mem_rd_data = 0;
    logic busy, wake, clr_sw, clr_hw, clr_fast, clr_exc, ack, mem_wr_en, mem_rd_en;
    logic commit, usp_upd, bk_upd;
    logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr, new_pc, new_psw, new_sp;
    logic [31:0] usp_val, bk_pc, bk_psw;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_sw(req_sw), .req_hw(req_hw), .req_fast(req_fast),
        .req_exc(req_exc), .hw_vec(hw_vec), .hw_lvl(hw_lvl), .sw_vec(sw_vec),
        .exc_code(exc_code), .cur_psw(cur_psw), .cur_pc(cur_pc), .cur_r0(cur_r0),
        .cur_isp(cur_isp), .tbl_base(tbl_base), .fast_pc(fast_pc), .busy(busy),
        .wake(wake), .clr_sw(clr_sw), .clr_hw(clr_hw), .clr_fast(clr_fast),
        .clr_exc(clr_exc), .ack(ack), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_rdy(mem_wr_rdy), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_rd_rdy(mem_rd_rdy),
        .commit(commit), .new_pc(new_pc), .new_psw(new_psw), .new_sp(new_sp),
        .usp_upd(usp_upd), .usp_val(usp_val), .bk_upd(bk_upd), .bk_pc(bk_pc),
        .bk_psw(bk_psw)
    );

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 commit
        logic [31:0] a, b, c, e, f, g;
        logic [1:0]  d;      // {usp_upd, bk_upd}
        string       tag;
    } item_t;

    item_t expq[$];
    int n_cmp = 0, n_bad = 0, n_wake = 0, n_ack = 0;
    int lat = 0, wcnt = 0, rcnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pending request registers: set by driver, cleared by the block's pulses.
    always @(posedge clk) begin
        if (!rst_n || drop_all) begin
            req_sw <= 0; req_hw <= 0; req_fast <= 0; req_exc <= 0;
        end else begin
            if (clr_sw) req_sw <= 0; else if (set_sw) req_sw <= 1;
            if (clr_hw) req_hw <= 0; else if (set_hw) req_hw <= 1;
            if (clr_fast) req_fast <= 0; else if (set_fast) req_fast <= 1;
            if (clr_exc) req_exc <= 0; else if (set_exc) req_exc <= 1;
        end
    end

    // Memory responder with a per-case wait-state count; read data = ~address.
    always @(posedge clk) begin
        #1;
        if (mem_wr_rdy) begin mem_wr_rdy = 0; wcnt = 0; end
        else if (mem_wr_en) begin
            if (wcnt >= lat) mem_wr_rdy = 1; else wcnt++;
        end
        if (mem_rd_rdy) begin mem_rd_rdy = 0; rcnt = 0; end
        else if (mem_rd_en) begin
            if (rcnt >= lat) begin mem_rd_rdy = 1; mem_rd_data = ~mem_rd_addr; end
            else rcnt++;
        end
    end

    // Monitor: compares every bus transfer and commit against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            item_t it;
            if (wake) n_wake++;
            if (ack) n_ack++;
            if (mem_wr_en && mem_wr_rdy) begin
                if (expq.size() == 0 || expq[0].kind != 0) chk(0, "R8 unexpected write", mem_wr_addr, 0);
                else begin
                    it = expq.pop_front();
                    chk(mem_wr_addr == it.a, {it.tag, " R7 write address"}, mem_wr_addr, it.a);
                    chk(mem_wr_data == it.b, {it.tag, " R7 write data"}, mem_wr_data, it.b);
                end
            end
            if (mem_rd_en && mem_rd_rdy) begin
                if (expq.size() == 0 || expq[0].kind != 1) chk(0, "R8 unexpected read", mem_rd_addr, 0);
                else begin
                    it = expq.pop_front();
                    chk(mem_rd_addr == it.a, {it.tag, " R11 vector address"}, mem_rd_addr, it.a);
                end
            end
            if (commit) begin
                if (expq.size() == 0 || expq[0].kind != 2) chk(0, "R12 unexpected commit", new_pc, 0);
                else begin
                    it = expq.pop_front();
                    chk(new_pc == it.a, {it.tag, " R11 new pc"}, new_pc, it.a);
                    chk(new_psw == it.b, {it.tag, " R9 new status"}, new_psw, it.b);
                    chk(new_sp == it.c, {it.tag, " R7 new sp"}, new_sp, it.c);
                    chk({usp_upd, bk_upd} == it.d, {it.tag, " R6 update flags"}, 32'({usp_upd, bk_upd}), 32'(it.d));
                    if (it.d[1]) chk(usp_val == it.e, {it.tag, " R6 usp value"}, usp_val, it.e);
                    if (it.d[0]) begin
                        chk(bk_pc == it.f, {it.tag, " R8 backup pc"}, bk_pc, it.f);
                        chk(bk_psw == it.g, {it.tag, " R8 backup status"}, bk_psw, it.g);
                    end
                end
            end
        end
    end

    function automatic logic [31:0] mk(input bit u, input bit i, input bit pm, input int lvl);
        return (32'(lvl) << 24) | (32'(pm) << 20) | (32'(u) << 17) | (32'(i) << 16) | 32'h0000_008F;
    endfunction

    // Push the items one entry produces; k: 0 exception, 1 fast, 2 hardware, 3 software.
    task automatic expect_entry(input int k, input string tag);
        item_t it;
        logic [31:0] b, p, adr;
        bit u;
        u = cur_psw[17];
        b = u ? cur_isp : cur_r0;
        p = cur_psw & ~32'h0013_0000;
        if (k == 1) p[27:24] = 4'hF;
        if (k == 2) p[27:24] = hw_lvl;
        it.tag = tag;
        if (k == 1) begin
            it.kind = 2; it.a = fast_pc; it.b = p; it.c = b; it.d = {u, 1'b1};
            it.e = cur_r0; it.f = cur_pc; it.g = cur_psw;
            expq.push_back(it);
        end else begin
            adr = (k == 0) ? 32'hFFFF_FFC0 + 32'(exc_code) * 4
                           : tbl_base + 32'((k == 2) ? hw_vec : sw_vec) * 4;
            it.kind = 0; it.a = b - 4; it.b = cur_psw; expq.push_back(it);
            it.kind = 0; it.a = b - 8; it.b = cur_pc;  expq.push_back(it);
            it.kind = 1; it.a = adr; expq.push_back(it);
            it.kind = 2; it.a = ~adr; it.b = p; it.c = b - 8; it.d = {u, 1'b0}; it.e = cur_r0;
            expq.push_back(it);
        end
    endtask

    task automatic raise(input bit s, input bit h, input bit f, input bit e);
        @(negedge clk); set_sw = s; set_hw = h; set_fast = f; set_exc = e;
        @(negedge clk); set_sw = 0; set_hw = 0; set_fast = 0; set_exc = 0;
    endtask

    task automatic drop();
        @(negedge clk); drop_all = 1;
        @(negedge clk); drop_all = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while ((expq.size() != 0 || busy) && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0 && !busy, {tag, " R12 sequence completes"}, 32'(expq.size()), 0);
        expq.delete();
    endtask

    // Run one case and check entry and acknowledge counts (R5, R10).
    task automatic run_case(input string tag, input int entries, input int acks);
        int w0 = n_wake, a0 = n_ack;
        wait_idle(tag);
        chk(n_wake - w0 == entries, {tag, " R5 wake pulses"}, 32'(n_wake - w0), 32'(entries));
        chk(n_ack - a0 == acks, {tag, " R10 ack pulses"}, 32'(n_ack - a0), 32'(acks));
    endtask

    task automatic reject(input string tag);
        int w0 = n_wake;
        repeat (30) @(negedge clk);
        chk(n_wake == w0 && !busy, tag, 32'(n_wake - w0), 0);
        drop();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk(!busy && !mem_wr_en && !mem_rd_en && !commit && !wake, "R12 reset outputs idle",
            32'({busy, mem_wr_en, mem_rd_en, commit, wake}), 0);

        // R1 R6 R7 R11: software entry from user mode, interrupts masked, level 15
        lat = 0; cur_psw = mk(1, 0, 1, 15);
        expect_entry(3, "R1 sw");
        raise(1, 0, 0, 0); run_case("R1 sw", 1, 0);

        // R2: level not below request level, then enable cleared
        lat = 1; cur_psw = mk(0, 1, 0, 9); hw_lvl = 9;
        raise(0, 1, 0, 0); reject("R2 hw level equal ignored");
        cur_psw = mk(0, 0, 0, 0);
        raise(0, 1, 0, 0); reject("R2 hw disabled ignored");

        // R2 R6 R9 R10: accepted hardware entry in supervisor mode
        lat = 2; cur_psw = mk(0, 1, 1, 3); hw_lvl = 9;
        expect_entry(2, "R2 hw");
        raise(0, 1, 0, 0); run_case("R2 hw", 1, 1);

        // R3 R8: fast entry from user mode at level 14
        lat = 0; cur_psw = mk(1, 1, 0, 14);
        expect_entry(1, "R3 fast");
        raise(0, 0, 1, 0); run_case("R3 fast", 1, 1);

        // R3: fast refused at level 15
        cur_psw = mk(0, 1, 0, 15);
        raise(0, 0, 1, 0); reject("R3 fast level 15 ignored");

        // R4: hardware and software together, hardware first then software
        lat = 1; cur_psw = mk(0, 1, 0, 1); hw_lvl = 5; hw_vec = 8'h7F; sw_vec = 8'h02;
        expect_entry(2, "R4 hw before sw");
        expect_entry(3, "R4 sw kept pending");
        raise(1, 1, 0, 0); run_case("R4 hw+sw", 2, 1);

        // R4: fast and hardware together, fast first then hardware
        lat = 0; cur_psw = mk(1, 1, 0, 2); hw_lvl = 6;
        expect_entry(1, "R4 fast before hw");
        expect_entry(2, "R4 hw kept pending");
        raise(0, 1, 1, 0); run_case("R4 fast+hw", 2, 2);

        // R4 R11: exception (code 30) over software, fixed base with wrap
        lat = 2; cur_psw = mk(0, 0, 0, 4); exc_code = 5'd30;
        expect_entry(0, "R11 exc 30");
        expect_entry(3, "R4 sw after exc");
        raise(1, 0, 0, 1); run_case("R4 exc+sw", 2, 0);

        // R11: exception code 25 from user mode
        lat = 1; cur_psw = mk(1, 1, 1, 7); exc_code = 5'd25;
        expect_entry(0, "R11 exc 25");
        raise(0, 0, 0, 1); run_case("R11 exc 25", 1, 0);

        summary();
    end
endmodule